// File: doc/BRIEF.md
# Queue Interrupt Status Aggregator

This block gathers per-endpoint events from a set of transmit and receive queue engines and presents them to software as a small register file with one interrupt line. Each engine signals a completion pulse per endpoint. It also signals error pulses for checksum faults, length faults and receipt of a zero-length packet. Completions are latched into a done-status register. Error pulses are latched into three per-endpoint error registers, but only where software has enabled them.

A read-only exception summary gives one flag per error kind, so an interrupt handler can see which error register to visit. Done status and the per-endpoint error registers are write-one-to-clear. Software can therefore write back the value it has just read to acknowledge exactly the events it saw. An event that arrives in the same cycle as its own clear is not lost. Endpoint 0 never uses a queue, so its bit position is never set in any per-endpoint field.

The register port is a single-cycle write strobe with a 4-bit word address and a combinational read. The interrupt output is a registered OR of all enabled done bits and all enabled summary flags.

Top module: `qisa_aggregator`

## Requirements
- R1: Done status is at address 0. A completion pulse on transmit endpoint n sets bit n, and one on receive endpoint n sets bit 16+n. The bit is readable after the clock edge that samples the pulse, whatever the done-enable register holds.
- R2: Endpoint 0 pulses never set any status bit, in done status or in any error register.
- R3: A write to address 0 clears every done bit written as 1 and leaves the bits written as 0 unchanged.
- R4: The irq output is registered. It is 1 one clock after some done bit is set while the matching bit of the done-enable register (address 1) is also set, and it drops one clock after that condition ends.
- R5: Error pulses are latched only if the matching enable bit is set. The error registers and their enables use these addresses and layouts:
  - Receive errors, address 4, enable at address 7: checksum in bits 15:0, length in bits 31:16.
  - Receive zero-length, address 5, enable at address 8: bits 15:0.
  - Transmit errors, address 6, enable at address 9: checksum in bits 15:0, length in bits 31:16.
- R6: The summary at address 2 has these bits: 0 receive checksum, 1 receive length, 2 receive zero-length, 3 transmit checksum, 4 transmit length. Each bit is the OR of its per-endpoint field.
- R7: Writes to the summary address have no effect.
- R8: Writing back a value read from an error register clears exactly those bits, and the summary follows.
- R9: A summary flag drives irq only if the matching bit of the exception-enable register (address 3, bits 4:0) is set.
- R10: If an event and a write-one-to-clear hit the same bit in the same cycle, the bit stays set.
- R11: The enable registers read back what was written. The exception enable keeps only bits 4:0, and the zero-length enable keeps only bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done_ev | input | NUM_EP | Transmit completion pulse per endpoint |
| rx_done_ev | input | NUM_EP | Receive completion pulse per endpoint |
| tx_cs_ev | input | NUM_EP | Transmit checksum error pulse |
| tx_len_ev | input | NUM_EP | Transmit length error pulse |
| rx_cs_ev | input | NUM_EP | Receive checksum error pulse |
| rx_len_ev | input | NUM_EP | Receive length error pulse |
| rx_zlp_ev | input | NUM_EP | Receive zero-length packet pulse |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps a single completion pulse across every endpoint position in both directions. This separates the transmit half from the receive half and shows that endpoint 0 is dropped. It then walks every error kind across every endpoint, checking the target register and the summary bit. This tells apart the five field positions and the write-back clear. Mixed multi-bit patterns with partial clears, an event colliding with its own clear, and enable-off versus enable-on runs show that masking and latching are separate. The interrupt is sampled on the cycle before and the cycle after each enable change to pin down its one-clock latency.

// File: rtl/qisa_pkg.sv
package qisa_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = 16;
    localparam int ADDR_W = 4;
    localparam int SUM_W  = 5;

    localparam logic [ADDR_W-1:0] A_DONE_STAT  = 4'd0;
    localparam logic [ADDR_W-1:0] A_DONE_EN    = 4'd1;
    localparam logic [ADDR_W-1:0] A_EXC_SUM    = 4'd2;
    localparam logic [ADDR_W-1:0] A_EXC_EN     = 4'd3;
    localparam logic [ADDR_W-1:0] A_RXERR_STAT = 4'd4;
    localparam logic [ADDR_W-1:0] A_RXZLP_STAT = 4'd5;
    localparam logic [ADDR_W-1:0] A_TXERR_STAT = 4'd6;
    localparam logic [ADDR_W-1:0] A_RXERR_EN   = 4'd7;
    localparam logic [ADDR_W-1:0] A_RXZLP_EN   = 4'd8;
    localparam logic [ADDR_W-1:0] A_TXERR_EN   = 4'd9;

    // Summary flags; the first member is the most significant bit.
    typedef struct packed {
        logic tx_len;
        logic tx_cs;
        logic rx_zlp;
        logic rx_len;
        logic rx_cs;
    } exc_sum_t;

    // Write strobes, one per clearable or writable register.
    typedef struct packed {
        logic done_clr;
        logic done_en;
        logic exc_en;
        logic rxerr_clr;
        logic rxzlp_clr;
        logic txerr_clr;
        logic rxerr_en;
        logic rxzlp_en;
        logic txerr_en;
    } wr_sel_t;

    // Implemented endpoint positions: endpoint 0 and those above the count are absent.
    function automatic logic [HALF_W-1:0] ep_mask(input int n_ep);
        logic [HALF_W-1:0] m;
        for (int i = 0; i < HALF_W; i++) begin
            m[i] = (i != 0) && (i < n_ep);
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] pack_halves(input logic [HALF_W-1:0] lo,
                                                      input logic [HALF_W-1:0] hi);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/qisa_w1c_bank.sv
module qisa_w1c_bank #(
    parameter int          W         = 32,
    parameter logic [W-1:0] IMPL_MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (IMPL_MASK[b]) begin : g_impl
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else begin
                    // a set in the same cycle overrides the clear
                    bit_q <= set_i[b] | (bit_q & ~clr_i[b]);
                end
            end
            assign q_o[b] = bit_q;
        end else begin : g_absent
            assign q_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/qisa_regport.sv
module qisa_regport
    import qisa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] done_q,
    input  exc_sum_t          sum_q,
    input  logic [DATA_W-1:0] rxerr_q,
    input  logic [HALF_W-1:0] rxzlp_q,
    input  logic [DATA_W-1:0] txerr_q,
    output logic [DATA_W-1:0] done_en_q,
    output exc_sum_t          exc_en_q,
    output logic [DATA_W-1:0] rxerr_en_q,
    output logic [HALF_W-1:0] rxzlp_en_q,
    output logic [DATA_W-1:0] txerr_en_q,
    output wr_sel_t           sel
);

    always_comb begin
        sel = '0;
        if (wr_en) begin
            unique case (addr)
                A_DONE_STAT:  sel.done_clr  = 1'b1;
                A_DONE_EN:    sel.done_en   = 1'b1;
                A_EXC_EN:     sel.exc_en    = 1'b1;
                A_RXERR_STAT: sel.rxerr_clr = 1'b1;
                A_RXZLP_STAT: sel.rxzlp_clr = 1'b1;
                A_TXERR_STAT: sel.txerr_clr = 1'b1;
                A_RXERR_EN:   sel.rxerr_en  = 1'b1;
                A_RXZLP_EN:   sel.rxzlp_en  = 1'b1;
                A_TXERR_EN:   sel.txerr_en  = 1'b1;
                default:      sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_en_q  <= '0;
            exc_en_q   <= '0;
            rxerr_en_q <= '0;
            rxzlp_en_q <= '0;
            txerr_en_q <= '0;
        end else begin
            if (sel.done_en)  done_en_q  <= wdata;
            if (sel.exc_en)   exc_en_q   <= exc_sum_t'(wdata[SUM_W-1:0]);
            if (sel.rxerr_en) rxerr_en_q <= wdata;
            if (sel.rxzlp_en) rxzlp_en_q <= wdata[HALF_W-1:0];
            if (sel.txerr_en) txerr_en_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_DONE_STAT:  rdata = done_q;
            A_DONE_EN:    rdata = done_en_q;
            A_EXC_SUM:    rdata = DATA_W'(sum_q);
            A_EXC_EN:     rdata = DATA_W'(exc_en_q);
            A_RXERR_STAT: rdata = rxerr_q;
            A_RXZLP_STAT: rdata = DATA_W'(rxzlp_q);
            A_TXERR_STAT: rdata = txerr_q;
            A_RXERR_EN:   rdata = rxerr_en_q;
            A_RXZLP_EN:   rdata = DATA_W'(rxzlp_en_q);
            A_TXERR_EN:   rdata = txerr_en_q;
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/qisa_irq_gen.sv
module qisa_irq_gen
    import qisa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] done_q,
    input  logic [DATA_W-1:0] done_en_q,
    input  logic [DATA_W-1:0] rxerr_q,
    input  logic [HALF_W-1:0] rxzlp_q,
    input  logic [DATA_W-1:0] txerr_q,
    input  exc_sum_t          exc_en_q,
    output exc_sum_t          sum_o,
    output logic              irq_o
);

    always_comb begin
        sum_o.rx_cs  = |rxerr_q[HALF_W-1:0];
        sum_o.rx_len = |rxerr_q[DATA_W-1:HALF_W];
        sum_o.rx_zlp = |rxzlp_q;
        sum_o.tx_cs  = |txerr_q[HALF_W-1:0];
        sum_o.tx_len = |txerr_q[DATA_W-1:HALF_W];
    end

    logic any_done;
    logic any_exc;
    assign any_done = |(done_q & done_en_q);
    assign any_exc  = |(sum_o & exc_en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= any_done | any_exc;
        end
    end

endmodule

// File: rtl/qisa_aggregator.sv
module qisa_aggregator
    import qisa_pkg::*;
#(
    parameter int NUM_EP = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EP-1:0] tx_done_ev,
    input  logic [NUM_EP-1:0] rx_done_ev,
    input  logic [NUM_EP-1:0] tx_cs_ev,
    input  logic [NUM_EP-1:0] tx_len_ev,
    input  logic [NUM_EP-1:0] rx_cs_ev,
    input  logic [NUM_EP-1:0] rx_len_ev,
    input  logic [NUM_EP-1:0] rx_zlp_ev,
    input  logic              reg_wr_en,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    localparam logic [HALF_W-1:0] EPM  = ep_mask(NUM_EP);
    localparam logic [DATA_W-1:0] EPM2 = pack_halves(EPM, EPM);

    // Widen an endpoint vector to a half-word and drop absent positions.
    function automatic logic [HALF_W-1:0] widen(input logic [NUM_EP-1:0] v);
        return HALF_W'(v) & EPM;
    endfunction

    logic [DATA_W-1:0] done_q, rxerr_q, txerr_q;
    logic [HALF_W-1:0] rxzlp_q;
    logic [DATA_W-1:0] done_en_q, rxerr_en_q, txerr_en_q;
    logic [HALF_W-1:0] rxzlp_en_q;
    exc_sum_t          exc_en_q;
    exc_sum_t          sum_q;
    wr_sel_t           sel;

    logic [DATA_W-1:0] done_set, rxerr_set, txerr_set;
    logic [HALF_W-1:0] rxzlp_set;
    logic [DATA_W-1:0] done_clr, rxerr_clr, txerr_clr;
    logic [HALF_W-1:0] rxzlp_clr;

    // Completions latch regardless of enables; errors latch only when enabled.
    assign done_set  = pack_halves(widen(tx_done_ev), widen(rx_done_ev));
    assign rxerr_set = pack_halves(widen(rx_cs_ev), widen(rx_len_ev)) & rxerr_en_q;
    assign rxzlp_set = widen(rx_zlp_ev) & rxzlp_en_q;
    assign txerr_set = pack_halves(widen(tx_cs_ev), widen(tx_len_ev)) & txerr_en_q;

    assign done_clr  = sel.done_clr  ? reg_wdata : '0;
    assign rxerr_clr = sel.rxerr_clr ? reg_wdata : '0;
    assign rxzlp_clr = sel.rxzlp_clr ? reg_wdata[HALF_W-1:0] : '0;
    assign txerr_clr = sel.txerr_clr ? reg_wdata : '0;

    qisa_w1c_bank #(.W(DATA_W), .IMPL_MASK(EPM2)) u_done (
        .clk(clk), .rst(rst), .set_i(done_set), .clr_i(done_clr), .q_o(done_q));

    qisa_w1c_bank #(.W(DATA_W), .IMPL_MASK(EPM2)) u_rxerr (
        .clk(clk), .rst(rst), .set_i(rxerr_set), .clr_i(rxerr_clr), .q_o(rxerr_q));

    qisa_w1c_bank #(.W(HALF_W), .IMPL_MASK(EPM)) u_rxzlp (
        .clk(clk), .rst(rst), .set_i(rxzlp_set), .clr_i(rxzlp_clr), .q_o(rxzlp_q));

    qisa_w1c_bank #(.W(DATA_W), .IMPL_MASK(EPM2)) u_txerr (
        .clk(clk), .rst(rst), .set_i(txerr_set), .clr_i(txerr_clr), .q_o(txerr_q));

    qisa_regport u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .done_q(done_q), .sum_q(sum_q), .rxerr_q(rxerr_q), .rxzlp_q(rxzlp_q),
        .txerr_q(txerr_q),
        .done_en_q(done_en_q), .exc_en_q(exc_en_q), .rxerr_en_q(rxerr_en_q),
        .rxzlp_en_q(rxzlp_en_q), .txerr_en_q(txerr_en_q), .sel(sel));

    qisa_irq_gen u_irq (
        .clk(clk), .rst(rst),
        .done_q(done_q), .done_en_q(done_en_q),
        .rxerr_q(rxerr_q), .rxzlp_q(rxzlp_q), .txerr_q(txerr_q),
        .exc_en_q(exc_en_q), .sum_o(sum_q), .irq_o(irq));

endmodule

// File: rtl/qisa_checker.sv
module qisa_checker #(
    parameter int NUM_EP = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_EP-1:0] tx_done_ev,
    input logic [NUM_EP-1:0] rx_done_ev,
    input logic              reg_wr_en,
    input logic [3:0]        reg_addr,
    input logic [31:0]       done_q,
    input logic [31:0]       done_en_q,
    input logic [4:0]        exc_en_q,
    input logic [31:0]       txerr_q,
    input logic [31:0]       txerr_en_q,
    input logic              irq
);

    logic [15:0] tx_w, rx_w;
    assign tx_w = 16'(tx_done_ev) & 16'hFFFE;
    assign rx_w = 16'(rx_done_ev) & 16'hFFFE;

    p_ep0_never_r2: assert property (@(posedge clk) disable iff (rst)
        !done_q[0] && !done_q[16] && !txerr_q[0] && !txerr_q[16]);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((done_q & $past({rx_w, tx_w})) == $past({rx_w, tx_w})));

    p_hold_without_access_r3: assert property (@(posedge clk) disable iff (rst)
        (!(reg_wr_en && reg_addr == 4'd0) && tx_done_ev == '0 && rx_done_ev == '0)
        |=> $stable(done_q));

    p_irq_masked_r4: assert property (@(posedge clk) disable iff (rst)
        (done_en_q == '0 && exc_en_q == '0) |=> !irq);

    p_err_gated_r5: assert property (@(posedge clk) disable iff (rst)
        (txerr_en_q == '0) |=> ((txerr_q & ~$past(txerr_q)) == '0));

endmodule

bind qisa_aggregator qisa_checker #(.NUM_EP(NUM_EP)) u_chk (
    .clk(clk), .rst(rst),
    .tx_done_ev(tx_done_ev), .rx_done_ev(rx_done_ev),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .done_q(done_q), .done_en_q(done_en_q), .exc_en_q(exc_en_q),
    .txerr_q(txerr_q), .txerr_en_q(txerr_en_q), .irq(irq));

// File: tb/qisa_aggregator_tb.sv
module qisa_aggregator_tb;

    localparam int NEP = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NEP-1:0]  tx_done_ev = '0, rx_done_ev = '0;
    logic [NEP-1:0]  tx_cs_ev = '0, tx_len_ev = '0;
    logic [NEP-1:0]  rx_cs_ev = '0, rx_len_ev = '0, rx_zlp_ev = '0;
    logic            reg_wr_en = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    qisa_aggregator #(.NUM_EP(NEP)) u_dut (
        .clk(clk), .rst(rst),
        .tx_done_ev(tx_done_ev), .rx_done_ev(rx_done_ev),
        .tx_cs_ev(tx_cs_ev), .tx_len_ev(tx_len_ev),
        .rx_cs_ev(rx_cs_ev), .rx_len_ev(rx_len_ev), .rx_zlp_ev(rx_zlp_ev),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq));

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    // kind: 0 rx checksum, 1 rx length, 2 rx zero-length, 3 tx checksum, 4 tx length
    task automatic pulse_err(input int kind, input int ep);
        logic [NEP-1:0] v;
        v = NEP'(1) << ep;
        case (kind)
            0: rx_cs_ev  = v;
            1: rx_len_ev = v;
            2: rx_zlp_ev = v;
            3: tx_cs_ev  = v;
            default: tx_len_ev = v;
        endcase
        tick();
        rx_cs_ev = '0; rx_len_ev = '0; rx_zlp_ev = '0; tx_cs_ev = '0; tx_len_ev = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        @(negedge clk);
        tick();
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        for (int a = 0; a < 10; a++) rdchk("reset", 4'(a), 32'h0);
        check("R4 reset irq", {31'b0, irq}, 32'h0);

        // R11 enable readback
        wr(4'd1, 32'hA5A5_5A5A); rdchk("R11 done_en", 4'd1, 32'hA5A5_5A5A);
        wr(4'd3, 32'hFFFF_FFFF); rdchk("R11 exc_en", 4'd3, 32'h0000_001F);
        wr(4'd8, 32'hFFFF_FFFF); rdchk("R11 zlp_en", 4'd8, 32'h0000_FFFF);
        wr(4'd7, 32'h1234_8765); rdchk("R11 rxerr_en", 4'd7, 32'h1234_8765);
        wr(4'd9, 32'h0F0F_F0F0); rdchk("R11 txerr_en", 4'd9, 32'h0F0F_F0F0);
        wr(4'd1, 32'h0); wr(4'd3, 32'h0); wr(4'd7, 32'h0); wr(4'd8, 32'h0); wr(4'd9, 32'h0);

        // R1 / R2 / R3 sweep of every endpoint position in both directions
        for (int ep = 0; ep < NEP; ep++) begin
            tx_done_ev = NEP'(1) << ep;
            tick();
            tx_done_ev = '0;
            rdchk("R1 tx done bit / R2 ep0", 4'd0, (ep == 0) ? 32'h0 : (32'h1 << ep));
            wr(4'd0, 32'hFFFF_FFFF);
            rdchk("R3 tx clear", 4'd0, 32'h0);
            rx_done_ev = NEP'(1) << ep;
            tick();
            rx_done_ev = '0;
            rdchk("R1 rx done bit / R2 ep0", 4'd0, (ep == 0) ? 32'h0 : (32'h1 << (16 + ep)));
            wr(4'd0, 32'hFFFF_FFFF);
            rdchk("R3 rx clear", 4'd0, 32'h0);
        end
        check("R4 irq stays low, enables off", {31'b0, irq}, 32'h0);

        // R3 partial clear of a mixed pattern
        tx_done_ev = 16'h00F0; rx_done_ev = 16'h0300;
        tick();
        tx_done_ev = '0; rx_done_ev = '0;
        rdchk("R1 mixed", 4'd0, 32'h0300_00F0);
        wr(4'd0, 32'h0100_0030);
        rdchk("R3 partial clear", 4'd0, 32'h0200_00C0);
        wr(4'd0, 32'h0);
        rdchk("R3 zero write", 4'd0, 32'h0200_00C0);

        // R10 event colliding with its own clear
        tx_done_ev = 16'h0040;
        wr(4'd0, 32'h0000_0040);
        tx_done_ev = '0;
        rdchk("R10 set wins done", 4'd0, 32'h0200_00C0);
        wr(4'd0, 32'hFFFF_FFFF);
        rdchk("R3 all clear", 4'd0, 32'h0);

        // R4 interrupt masking and latency
        tx_done_ev = 16'h0020;
        tick();
        tx_done_ev = '0;
        tick();
        check("R4 masked irq", {31'b0, irq}, 32'h0);
        wr(4'd1, 32'h0000_0020);
        check("R4 irq not yet", {31'b0, irq}, 32'h0);
        tick();
        check("R4 irq raised", {31'b0, irq}, 32'h1);
        wr(4'd0, 32'h0000_0020);
        check("R4 irq one cycle after clear", {31'b0, irq}, 32'h1);
        tick();
        check("R4 irq dropped", {31'b0, irq}, 32'h0);
        rx_done_ev = 16'h0004;
        tick();
        rx_done_ev = '0;
        check("R4 irq off-bit enable", {31'b0, irq}, 32'h0);
        tick();
        check("R4 irq wrong bit stays low", {31'b0, irq}, 32'h0);
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd1, 32'h0);

        // R5 gating
        pulse_err(3, 3);
        rdchk("R5 tx cs gated off", 4'd6, 32'h0);
        rdchk("R5 summary stays 0", 4'd2, 32'h0);
        wr(4'd9, 32'h0000_FFFF);
        tx_cs_ev = 16'h0008; tx_len_ev = 16'h0008;
        tick();
        tx_cs_ev = '0; tx_len_ev = '0;
        rdchk("R5 only cs half enabled", 4'd6, 32'h0000_0008);
        wr(4'd6, 32'h0000_0008);
        rdchk("R8 tx cs clear", 4'd6, 32'h0);

        // R6 / R8 sweep over every kind and endpoint
        wr(4'd7, 32'hFFFF_FFFF); wr(4'd8, 32'hFFFF_FFFF); wr(4'd9, 32'hFFFF_FFFF);
        for (int k = 0; k < 5; k++) begin
            for (int ep = 0; ep < NEP; ep++) begin
                logic [3:0]  ra;
                logic [31:0] eb;
                ra = (k < 2) ? 4'd4 : ((k == 2) ? 4'd5 : 4'd6);
                eb = (ep == 0) ? 32'h0 :
                     ((k == 1 || k == 4) ? (32'h1 << (16 + ep)) : (32'h1 << ep));
                pulse_err(k, ep);
                rd(ra, d);
                check("R5 err latch / R2 ep0", d, eb);
                rdchk("R6 summary flag", 4'd2, (ep == 0) ? 32'h0 : (32'h1 << k));
                wr(ra, d);
                rdchk("R8 write-back clears", ra, 32'h0);
                rdchk("R8 summary follows", 4'd2, 32'h0);
            end
        end

        // R7 summary read-only, R9 exception mask, R10 on error register
        pulse_err(3, 7);
        wr(4'd2, 32'h0);
        rdchk("R7 summary unaffected", 4'd2, 32'h0000_0008);
        tick();
        check("R9 masked exception", {31'b0, irq}, 32'h0);
        wr(4'd3, 32'h0000_0001);
        tick();
        check("R9 other flag enabled", {31'b0, irq}, 32'h0);
        wr(4'd3, 32'h0000_0008);
        tick();
        check("R9 matching flag", {31'b0, irq}, 32'h1);
        tx_cs_ev = 16'h0080;
        wr(4'd6, 32'h0000_0080);
        tx_cs_ev = '0;
        rdchk("R10 set wins error", 4'd6, 32'h0000_0080);
        wr(4'd6, 32'h0000_0080);
        tick();
        check("R9 irq drops", {31'b0, irq}, 32'h0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule